// File: doc/BRIEF.md
# Two-Agent Steering Lock

This block arbitrates ownership of a shared steering selector register between two bus agents: the host driver and an on-chip firmware agent. Each agent has its own register port, and both ports decode the same lock offset. An agent claims the lock by reading that offset. The read returns 1 in bit 0 when the agent now holds the lock and 0 when it does not. The owner gives the lock back by writing a value with bit 0 set.

Each agent also raises a request whenever it wants to write the steering selector. The block passes that request on as a write enable only while the requesting agent holds the lock. This keeps the two agents' steering sequences from interleaving. The requester's retry and timeout policy is outside this block, and so is the selector register itself.

Top module: `steer_lock_top`

## Requirements
- R1: A read of the lock offset (default 0xFD0) while the lock is free grants it to the reader. One cycle later, rvalid is high and rdata is 1.
- R2: A read of the lock offset while the other agent holds the lock returns rdata 0 and leaves ownership unchanged.
- R3: A read by the current owner returns rdata 1 and leaves the owner unchanged.
- R4: A write to the lock offset with wdata bit 0 = 1 from the owner frees the lock. After that, the other agent can acquire it.
- R5: A write with wdata bit 0 = 1 from an agent that does not own the lock is ignored.
- R6: A write with wdata bit 0 = 0 is ignored, including when it comes from the owner.
- R7: When both agents read in the same cycle while the lock is free, exactly one is granted. The grant goes to the host on the first such collision after reset and then alternates host/firmware on each later collision.
- R8: An agent's selector write enable is high only while that agent requests a selector write and holds the lock.
- R9: Accesses to any other offset produce no read response and do not change ownership.
- R10: After reset the lock is free, both rvalid outputs are low, and no selector write enable is asserted.
- R11: At most one agent holds the lock at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host register access strobe |
| host_we | input | 1 | Host access is a write |
| host_addr | input | ADDR_W | Host register offset |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, bit 0 = lock held |
| host_rvalid | output | 1 | Host read response valid |
| host_sel_req | input | 1 | Host wants to write the steering selector |
| host_sel_we | output | 1 | Host selector write enable |
| fw_req | input | 1 | Firmware register access strobe |
| fw_we | input | 1 | Firmware access is a write |
| fw_addr | input | ADDR_W | Firmware register offset |
| fw_wdata | input | DATA_W | Firmware write data |
| fw_rdata | output | DATA_W | Firmware read data, bit 0 = lock held |
| fw_rvalid | output | 1 | Firmware read response valid |
| fw_sel_req | input | 1 | Firmware wants to write the steering selector |
| fw_sel_we | output | 1 | Firmware selector write enable |

## Verification
The assertions assume that each agent presents at most one access per cycle, and that the write flag is meaningful only while its strobe is high. The bench drives every access for exactly one cycle on the falling edge. It never raises a strobe with unknown address or data, and it drops each strobe before the next access. Collisions are created on purpose by strobing both ports in the same cycle, so the alternating grant is exercised in both directions.

// File: rtl/steer_lock_pkg.sv
package steer_lock_pkg;
  localparam int NUM_AGENTS = 2;
  localparam int AGENT_HOST = 0;
  localparam int AGENT_FW   = 1;
  typedef logic [NUM_AGENTS-1:0] agent_vec_t;
endpackage

// File: rtl/steer_lock_arb.sv
module steer_lock_arb
  import steer_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  agent_vec_t claim_i,
  input  agent_vec_t release_i,
  output agent_vec_t owner_q_o,
  output agent_vec_t owner_d_o
);
  agent_vec_t owner_q, owner_d;
  logic       fw_turn_q, fw_turn_d;

  always_comb begin
    owner_d   = owner_q;
    fw_turn_d = fw_turn_q;
    if (owner_q == '0) begin
      if (&claim_i) begin
        owner_d   = fw_turn_q ? agent_vec_t'(1 << AGENT_FW) : agent_vec_t'(1 << AGENT_HOST);
        fw_turn_d = ~fw_turn_q;
      end else if (claim_i[AGENT_HOST]) begin
        owner_d = agent_vec_t'(1 << AGENT_HOST);
      end else if (claim_i[AGENT_FW]) begin
        owner_d = agent_vec_t'(1 << AGENT_FW);
      end
    end else if (|(owner_q & release_i)) begin
      owner_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q   <= '0;
      fw_turn_q <= 1'b0;
    end else begin
      owner_q   <= owner_d;
      fw_turn_q <= fw_turn_d;
    end
  end

  assign owner_q_o = owner_q;
  assign owner_d_o = owner_d;

  assert_single_owner_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(owner_q));

  assert_collision_grants_one_R7: assert property (@(posedge clk) disable iff (rst)
    (owner_q == '0 && &claim_i) |=> $countones(owner_q) == 1);

  generate
    for (genvar g = 0; g < NUM_AGENTS; g++) begin : g_chk
      assert_owner_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (owner_q[g] && !release_i[g]) |=> owner_q[g]);
      assert_release_frees_R4: assert property (@(posedge clk) disable iff (rst)
        (owner_q[g] && release_i[g]) |=> owner_q == '0);
    end
  endgenerate
endmodule

// File: rtl/steer_lock_port.sv
module steer_lock_port #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 12'hFD0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              holds_next_i,
  input  logic              holds_now_i,
  output logic              claim_o,
  output logic              release_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic hit;
  logic [DATA_W-1:0] rdata_q;
  logic rvalid_q;

  assign hit       = req_i && (addr_i == LOCK_ADDR);
  assign claim_o   = hit && !we_i;
  assign release_o = hit && we_i && wdata_i[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= claim_o;
      rdata_q  <= claim_o ? DATA_W'(holds_next_i) : '0;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  assert_grant_means_owner_R1: assert property (@(posedge clk) disable iff (rst)
    (rvalid_q && rdata_q[0]) |-> holds_now_i);

  assert_no_response_off_addr_R9: assert property (@(posedge clk) disable iff (rst)
    (req_i && (addr_i != LOCK_ADDR)) |=> !rvalid_q);
endmodule

// File: rtl/steer_lock_top.sv
module steer_lock_top
  import steer_lock_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 12'hFD0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  input  logic              host_sel_req,
  output logic              host_sel_we,
  input  logic              fw_req,
  input  logic              fw_we,
  input  logic [ADDR_W-1:0] fw_addr,
  input  logic [DATA_W-1:0] fw_wdata,
  output logic [DATA_W-1:0] fw_rdata,
  output logic              fw_rvalid,
  input  logic              fw_sel_req,
  output logic              fw_sel_we
);
  logic [NUM_AGENTS-1:0]             req_a, we_a, rvalid_a;
  logic [NUM_AGENTS-1:0][ADDR_W-1:0] addr_a;
  logic [NUM_AGENTS-1:0][DATA_W-1:0] wdata_a, rdata_a;
  agent_vec_t claim, rel, owner_q, owner_d, sel_req_a;

  assign req_a     = {fw_req, host_req};
  assign we_a      = {fw_we, host_we};
  assign addr_a    = {fw_addr, host_addr};
  assign wdata_a   = {fw_wdata, host_wdata};
  assign sel_req_a = {fw_sel_req, host_sel_req};

  generate
    for (genvar g = 0; g < NUM_AGENTS; g++) begin : g_port
      steer_lock_port #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_ADDR(LOCK_ADDR)
      ) u_port (
        .clk(clk), .rst(rst),
        .req_i(req_a[g]), .we_i(we_a[g]), .addr_i(addr_a[g]), .wdata_i(wdata_a[g]),
        .holds_next_i(owner_d[g]), .holds_now_i(owner_q[g]),
        .claim_o(claim[g]), .release_o(rel[g]),
        .rdata_o(rdata_a[g]), .rvalid_o(rvalid_a[g])
      );
    end
  endgenerate

  steer_lock_arb u_arb (
    .clk(clk), .rst(rst),
    .claim_i(claim), .release_i(rel),
    .owner_q_o(owner_q), .owner_d_o(owner_d)
  );

  assign host_sel_we = host_sel_req && owner_q[AGENT_HOST];
  assign fw_sel_we   = fw_sel_req && owner_q[AGENT_FW];
  assign host_rdata  = rdata_a[AGENT_HOST];
  assign host_rvalid = rvalid_a[AGENT_HOST];
  assign fw_rdata    = rdata_a[AGENT_FW];
  assign fw_rvalid   = rvalid_a[AGENT_FW];

  assert_sel_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(host_sel_we && fw_sel_we));
endmodule

// File: tb/steer_lock_top_tb.sv
module steer_lock_top_tb;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam logic [AW-1:0] LK = 12'hFD0;

  logic clk = 0, rst = 1;
  logic h_req = 0, h_we = 0, h_sreq = 0, f_req = 0, f_we = 0, f_sreq = 0;
  logic [AW-1:0] h_addr = '0, f_addr = '0;
  logic [DW-1:0] h_wd = '0, f_wd = '0, h_rd, f_rd;
  logic h_rv, f_rv, h_swe, f_swe;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  steer_lock_top u_dut (
    .clk(clk), .rst(rst),
    .host_req(h_req), .host_we(h_we), .host_addr(h_addr), .host_wdata(h_wd),
    .host_rdata(h_rd), .host_rvalid(h_rv), .host_sel_req(h_sreq), .host_sel_we(h_swe),
    .fw_req(f_req), .fw_we(f_we), .fw_addr(f_addr), .fw_wdata(f_wd),
    .fw_rdata(f_rd), .fw_rvalid(f_rv), .fw_sel_req(f_sreq), .fw_sel_we(f_swe)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one cycle access on host (0) or fw (1); returns the response seen after the edge
  task automatic access(int who, logic we, logic [AW-1:0] a, logic [DW-1:0] d,
                        output logic rv, output logic [DW-1:0] rd);
    @(negedge clk);
    if (who == 0) begin h_req = 1; h_we = we; h_addr = a; h_wd = d; end
    else begin f_req = 1; f_we = we; f_addr = a; f_wd = d; end
    @(negedge clk);
    h_req = 0; f_req = 0;
    rv = (who == 0) ? h_rv : f_rv;
    rd = (who == 0) ? h_rd : f_rd;
  endtask

  task automatic rd_expect(int who, logic [DW-1:0] exp, string req);
    logic rv; logic [DW-1:0] rd;
    access(who, 1'b0, LK, '0, rv, rd);
    check(req, rv, 1'b1);
    check(req, rd, exp);
  endtask

  task automatic wr(int who, logic [AW-1:0] a, logic [DW-1:0] d, string req);
    logic rv; logic [DW-1:0] rd;
    access(who, 1'b1, a, d, rv, rd);
    check(req, rv, 1'b0);
  endtask

  task automatic both_read(logic [DW-1:0] exp_h, logic [DW-1:0] exp_f);
    @(negedge clk);
    h_req = 1; h_we = 0; h_addr = LK;
    f_req = 1; f_we = 0; f_addr = LK;
    @(negedge clk);
    h_req = 0; f_req = 0;
    check("R7 host", h_rd, exp_h);
    check("R7 fw", f_rd, exp_f);
    check("R11", h_rd[0] & f_rd[0], 1'b0);
  endtask

  task automatic t_reset;
    h_sreq = 1; f_sreq = 1;
    #1;
    check("R10 host rvalid", h_rv, 1'b0);
    check("R10 fw rvalid", f_rv, 1'b0);
    check("R10 sel", {h_swe, f_swe}, 2'b00);
    h_sreq = 0; f_sreq = 0;
  endtask

  task automatic t_acquire;
    rd_expect(0, 1, "R1 host free read");
    rd_expect(1, 0, "R2 fw blocked");
    rd_expect(0, 1, "R3 host reread");
    h_sreq = 1; f_sreq = 1;
    #1;
    check("R8 owner sel", h_swe, 1'b1);
    check("R8 non-owner sel", f_swe, 1'b0);
    h_sreq = 0; f_sreq = 0;
  endtask

  task automatic t_ignored_writes;
    wr(1, LK, 32'h1, "R5 fw write");
    rd_expect(1, 0, "R5 fw still blocked");
    rd_expect(0, 1, "R5 host still owner");
    wr(0, LK, 32'h2, "R6 host write0");
    rd_expect(1, 0, "R6 fw blocked");
    rd_expect(0, 1, "R6 host owner");
  endtask

  task automatic t_other_addr;
    logic rv; logic [DW-1:0] rd;
    access(0, 1'b0, LK + 12'h4, '0, rv, rd);
    check("R9 no rvalid", rv, 1'b0);
    wr(0, LK + 12'h4, 32'h1, "R9 off write");
    rd_expect(1, 0, "R9 lock kept");
  endtask

  task automatic t_release;
    wr(0, LK, 32'h1, "R4 host release");
    rd_expect(1, 1, "R4 fw acquires");
    f_sreq = 1; h_sreq = 1;
    #1;
    check("R8 fw sel", {h_swe, f_swe}, 2'b01);
    f_sreq = 0; h_sreq = 0;
    wr(1, LK, 32'h1, "R4 fw release");
  endtask

  task automatic t_collision;
    both_read(1, 0);
    wr(0, LK, 32'h1, "R7 rel");
    both_read(0, 1);
    wr(1, LK, 32'h1, "R7 rel");
    both_read(1, 0);
    wr(0, LK, 32'h1, "R7 rel");
    rd_expect(1, 1, "R7 free after");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    t_acquire();
    t_ignored_writes();
    t_other_addr();
    t_release();
    t_collision();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #100000;
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule